// File: doc/BRIEF.md
# Four-Way Recency Replacement Tracker

This block keeps an exact recency order for the four ways of every set in a set-associative cache. Each way of a set holds a 2-bit rank: 0 means most recently used, 3 means least recently used. The four ranks of a set are always a permutation of 0 to 3. The tag store and the data store sit outside this block.

A cache controller reports each hit, and each fill after a miss, as one update event. The event carries a set number and a way number. For any requested set, the controller also reads a victim way. For that read it supplies the set's valid bits, so that an empty way is taken before the recency order is consulted. The victim is computed without a clock from the stored ranks. If an update and a query name the same set in the same cycle, the query therefore sees the order as it stood before the update.

Top module: `lru4_tracker`

## Requirements
- R1: After reset, every set holds ranks 0, 1, 2, 3 for ways 0, 1, 2, 3. A query with all four valid bits set therefore returns way 3 for every set.
- R2: The four ranks of each set always form a permutation of 0 to 3 (rank 0 = most recent, rank 3 = least recent).
- R3: An update to a way gives that way rank 0. Every way of the same set whose rank was lower than the updated way's old rank moves down by one rank.
- R4: On an update, ways of the same set whose rank was higher than the updated way's old rank keep their rank.
- R5: When all four valid bits are 1, the victim is the way holding rank 3. A fill reported on that way makes it rank 0 and ages every other way of the set by one rank.
- R6: When any valid bit is 0, the victim is the lowest-numbered way whose valid bit is 0, whatever the ranks are. `qry_valid[i]` belongs to way i.
- R7: An update and a query to the same set in the same cycle return the victim computed from the ranks before that update.
- R8: An update to one set leaves the ranks of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Hit or fill event this cycle |
| upd_set | input | $clog2(NUM_SETS) | Set of the event |
| upd_way | input | 2 | Way accessed or filled |
| qry_set | input | $clog2(NUM_SETS) | Set whose victim is requested |
| qry_valid | input | 4 | Valid bits of the queried set, bit i = way i |
| victim_way | output | 2 | Way to replace in the queried set |

## Verification
The bench builds the tracker with NUM_SETS = 4. With only four sets, a long random stream lands on every set many times. This produces repeated hits on the most-recent way, hits deep in the order, and fills on the least-recent way. It also produces many cycles where the update and the query name the same set. A directed sequence on one set fills four empty ways one after another and then evicts the oldest way. It then promotes a way from the middle of the order, and after each step the bench compares the victim with a behavioural list model.

// File: rtl/lru4_pkg.sv
// Shared types for the four-way recency tracker.
// Assumes exactly four ways per set; rank 0 is most recent, 3 least recent.
package lru4_pkg;
    localparam int WAYS   = 4;
    localparam int RANK_W = 2;
    typedef logic [RANK_W-1:0] rank_t;
    typedef rank_t [WAYS-1:0]  set_ranks_t;
    localparam rank_t RANK_NEWEST = 2'd0;
    localparam rank_t RANK_OLDEST = 2'd3;
endpackage

// File: rtl/lru4_rank_update.sv
// Computes the next ranks of one set after a hit or fill on a way.
// Assumes cur_ranks is a permutation of 0..3; the result is again one.
module lru4_rank_update
    import lru4_pkg::*;
(
    input  set_ranks_t  cur_ranks,
    input  logic [1:0]  touch_way,
    output set_ranks_t  nxt_ranks
);
    rank_t touched_rank;

    // Rank held by the touched way before the event.
    always_comb touched_rank = cur_ranks[touch_way];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Per way: promote the touched way, demote newer ones, keep older ones.
        always_comb begin
            if (touch_way == 2'(w))
                nxt_ranks[w] = RANK_NEWEST;
            else if (cur_ranks[w] < touched_rank)
                nxt_ranks[w] = cur_ranks[w] + 2'd1;
            else
                nxt_ranks[w] = cur_ranks[w];
        end
    end
endmodule

// File: rtl/lru4_victim_pick.sv
// Picks the victim way of one set: lowest invalid way first, else the oldest.
// Assumes ranks is a permutation of 0..3 so exactly one way is oldest.
module lru4_victim_pick
    import lru4_pkg::*;
(
    input  set_ranks_t  ranks,
    input  logic [3:0]  valid,
    output logic [1:0]  victim
);
    logic [1:0] first_empty;
    logic [1:0] oldest;

    // Lowest-numbered invalid way (scan from the top so the lowest wins).
    always_comb begin
        first_empty = 2'd0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid[w]) first_empty = 2'(w);
    end

    // Way holding the oldest rank.
    always_comb begin
        oldest = 2'd0;
        for (int w = 0; w < WAYS; w++)
            if (ranks[w] == RANK_OLDEST) oldest = 2'(w);
    end

    // Empty ways take precedence over recency.
    always_comb victim = (&valid) ? oldest : first_empty;
endmodule

// File: rtl/lru4_tracker.sv
// True-LRU tracker for a four-way set-associative cache.
// Holds one permutation of ranks per set, applies one hit/fill event per
// cycle and answers one victim query per cycle from the pre-update state.
// Assumes NUM_SETS is a power of two and the caller reports fills on the
// way it was handed as victim.
module lru4_tracker
    import lru4_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [1:0]       upd_way,
    input  logic [SET_W-1:0] qry_set,
    input  logic [3:0]       qry_valid,
    output logic [1:0]       victim_way
);
    set_ranks_t rank_q [NUM_SETS];
    set_ranks_t upd_cur;
    set_ranks_t upd_nxt;
    set_ranks_t qry_ranks;

    // Read ports of the rank array for the update and the query.
    always_comb begin
        upd_cur   = rank_q[upd_set];
        qry_ranks = rank_q[qry_set];
    end

    lru4_rank_update u_update (
        .cur_ranks (upd_cur),
        .touch_way (upd_way),
        .nxt_ranks (upd_nxt)
    );

    lru4_victim_pick u_victim (
        .ranks  (qry_ranks),
        .valid  (qry_valid),
        .victim (victim_way)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        // Per set: load reset order, or take the new ranks when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rank_q[s] <= {2'd3, 2'd2, 2'd1, 2'd0};
            else if (upd_en && upd_set == SET_W'(s))
                rank_q[s] <= upd_nxt;
        end
    end

    // ---------------- assertions ----------------
    logic             chk_vld;
    logic [SET_W-1:0] chk_set;
    logic [1:0]       chk_way;
    set_ranks_t       chk_prev;
    set_ranks_t       chk_now;
    logic [3:0]       qry_seen;
    logic             newer_ok;
    logic             older_ok;

    // Remember the last event so its effect can be checked one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vld  <= 1'b0;
            chk_set  <= '0;
            chk_way  <= 2'd0;
            chk_prev <= '0;
        end else begin
            chk_vld  <= upd_en;
            chk_set  <= upd_set;
            chk_way  <= upd_way;
            chk_prev <= upd_cur;
        end
    end

    // Compare the stored ranks of the last updated set against its old ranks.
    always_comb begin
        chk_now  = rank_q[chk_set];
        newer_ok = 1'b1;
        older_ok = 1'b1;
        for (int w = 0; w < WAYS; w++) begin
            if (2'(w) != chk_way && chk_prev[w] < chk_prev[chk_way]
                && chk_now[w] != chk_prev[w] + 2'd1) newer_ok = 1'b0;
            if (chk_prev[w] > chk_prev[chk_way] && chk_now[w] != chk_prev[w])
                older_ok = 1'b0;
        end
    end

    // Which rank values appear in the queried set.
    always_comb begin
        qry_seen = 4'b0;
        for (int w = 0; w < WAYS; w++) qry_seen[qry_ranks[w]] = 1'b1;
    end

    AST_RANKS_PERMUTE: assert property (@(posedge clk) disable iff (!rst_n)
        qry_seen == 4'hF); // R2
    AST_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |-> chk_now[chk_way] == RANK_NEWEST); // R3
    AST_NEWER_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |-> newer_ok); // R3
    AST_OLDER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |-> older_ok); // R4
    AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid != 4'hF) |-> !qry_valid[victim_way]); // R6
    AST_FULL_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid == 4'hF) |-> qry_ranks[victim_way] == RANK_OLDEST); // R5
endmodule

// File: tb/lru4_tracker_tb_top.sv
// Self-checking bench: behavioural recency lists per set, compared each cycle.
module lru4_tracker_tb_top;
    localparam int NSETS = 4;
    localparam int SW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_en = 1'b0;
    logic [SW-1:0] upd_set = '0;
    logic [1:0]    upd_way = 2'd0;
    logic [SW-1:0] qry_set = '0;
    logic [3:0]    qry_valid = 4'hF;
    logic [1:0]    victim_way;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int order [NSETS][4];   // order[s][0] newest .. order[s][3] oldest

    always #2.5 clk = ~clk;

    lru4_tracker #(.NUM_SETS(NSETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_set(upd_set),
        .upd_way(upd_way), .qry_set(qry_set), .qry_valid(qry_valid),
        .victim_way(victim_way)
    );

    function automatic int model_victim(int s, bit [3:0] v);
        for (int w = 0; w < 4; w++) if (!v[w]) return w;
        return order[s][3];
    endfunction

    function automatic void model_touch(int s, int w);
        int p = 0;
        for (int i = 0; i < 4; i++) if (order[s][i] == w) p = i;
        for (int i = p; i > 0; i--) order[s][i] = order[s][i-1];
        order[s][0] = w;
    endfunction

    // One cycle: drive, check victim before the edge, then advance the model.
    task automatic step(bit en, int us, int uw, int qs, bit [3:0] qv, string tag);
        int exp_v;
        @(negedge clk);
        upd_en = en; upd_set = SW'(us); upd_way = 2'(uw);
        qry_set = SW'(qs); qry_valid = qv;
        #1;
        exp_v = model_victim(qs, qv);
        checks++;
        if (victim_way !== 2'(exp_v)) begin
            errors++;
            $display("FAIL %s: set %0d valid %b victim %0d expected %0d",
                     tag, qs, qv, victim_way, exp_v);
        end
        if (en) model_touch(us, uw);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < 4; w++) order[s][w] = w;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset order, every set's oldest is way 3
        for (int s = 0; s < NSETS; s++) step(0, 0, 0, s, 4'hF, "R1 reset order");
        // R6: empty ways win regardless of ranks
        step(0, 0, 0, 1, 4'b1011, "R6 lowest empty way");
        step(0, 0, 0, 1, 4'b0110, "R6 lowest empty way");
        // Directed fill of set 2: A,C,B,D into ways 0..3, then E, then hit B
        step(1, 2, 0, 2, 4'b0000, "R6 fill empty A");
        step(1, 2, 1, 2, 4'b0001, "R6 fill empty C");
        step(1, 2, 2, 2, 4'b0011, "R6 fill empty B");
        step(1, 2, 3, 2, 4'b0111, "R6 fill empty D");
        step(1, 2, 0, 2, 4'hF,    "R5 full set evicts A");
        step(1, 2, 2, 2, 4'hF,    "R5 victim after fill E");
        step(0, 0, 0, 2, 4'hF,    "R4 oldest kept after hit B");
        step(1, 2, 1, 2, 4'hF,    "R4 hit oldest");
        step(0, 0, 0, 2, 4'hF,    "R3 double demotion to oldest");
        step(1, 2, 0, 2, 4'hF,    "R3 hit mid");
        step(1, 2, 3, 2, 4'hF,    "R3 hit oldest");
        step(0, 0, 0, 2, 4'hF,    "R3 after promotions");
        // R8: other sets untouched by set 2 traffic
        step(0, 0, 0, 0, 4'hF, "R8 set 0 unchanged");
        step(0, 0, 0, 3, 4'hF, "R8 set 3 unchanged");
        // R7: same-set update and query see the old order
        step(1, 3, 3, 3, 4'hF, "R7 same-cycle query");
        step(0, 0, 0, 3, 4'hF, "R7 after same-cycle update");

        // Random traffic: R2/R3/R4/R5/R7/R8 against the model
        for (int i = 0; i < 3000; i++) begin
            int us = $urandom_range(0, NSETS - 1);
            int qs = ($urandom_range(0, 3) == 0) ? us : $urandom_range(0, NSETS - 1);
            bit [3:0] qv = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
            int uw = ($urandom_range(0, 1) == 0) ? order[us][3] : $urandom_range(0, 3);
            step($urandom_range(0, 4) != 0, us, uw, qs, qv, "R2 random traffic");
        end
        finish_run();
    end
endmodule